// File: doc/BRIEF.md
# Grayscale Serial Shifter

This block moves a set of 12-bit grayscale levels out to a chain of constant-current LED driver chips. It keeps one holding register for every channel; a host writes a channel by presenting an index and a level on a valid/ready write port. Every write that is accepted bumps a change counter. The block never stalls this port, so `wr_ready` is always high. A write to an index outside the channel range is dropped and is not counted.

Once per frame a sequencer pulses `frame_req`. If no write has been counted since the last transfer, the block sends nothing and answers with `done` on the next cycle. Otherwise it copies every holding register into a shift register and clears the change counter. It then sends one clock pulse that carries no data. After that it shifts all channels out on `sdata`/`sclk`, channel 0 first and most significant bit first. It then pulses `latch` and finishes with `done`.

Each serial clock phase lasts `CLK_DIV` system clocks. The channel count is a parameter and is a multiple of 16, one group of 16 for each chained chip.

Top module: `gs_serial_shifter`

## Requirements
- R1: Each channel level is 12 bits wide and is sent most significant bit first, one bit per rising edge of `sclk`.
- R2: Channels go out in index order, channel 0 first and channel NUM_CH-1 last, giving NUM_CH*12 data edges per transfer.
- R3: Every transfer starts with exactly one extra `sclk` pulse, with `sdata` low, before the first data bit.
- R4: For each bit, `sdata` is set while `sclk` is low, then `sclk` goes high and then low; `sdata` does not change while `sclk` is high.
- R5: After the last bit, `latch` pulses high exactly once while `sclk` stays low.
- R6: Each accepted write increments the change counter. The counter is cleared when a transfer starts, except that a write accepted in that same cycle leaves it at one.
- R7: If the change counter is zero when `frame_req` arrives in idle, no `sclk` or `latch` activity occurs and `done` is high in the following cycle.
- R8: Levels are captured when a transfer starts. A write made while shifting appears only in the next transfer.
- R9: Every `sclk` high phase and the `latch` high phase last exactly CLK_DIV clock cycles.
- R10: `done` is a single-cycle pulse, issued once per request after `latch` falls. A `frame_req` that arrives during a transfer is ignored.
- R11: `wr_ready` is always high. A write whose index is NUM_CH or above changes no level and does not count as a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_index | input | ADDR_W | Channel index of the write |
| wr_value | input | GS_W | Grayscale level to store |
| frame_req | input | 1 | Per-frame transfer request pulse |
| sdata | output | 1 | Serial data to the driver chain |
| sclk | output | 1 | Serial clock to the driver chain |
| latch | output | 1 | Latch strobe, pulsed after the shift |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded assertions check the following on every cycle:
- `sdata` holds steady while `sclk` is high.
- `latch` never overlaps `sclk`.
- `done` lasts one cycle only.
- An empty request is answered at once.
- The change counter clears or increments as it should.

Only the bench scenarios can show the rest:
- The bit order across channels.
- The single leading dummy pulse.
- The phase widths.
- That a write made during a transfer waits for the next frame.
- That out-of-range writes and requests made while busy have no effect.

// File: rtl/gs_shift_pkg.sv
package gs_shift_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE_HI,
    ST_PRE_LO,
    ST_SETUP,
    ST_BIT_HI,
    ST_BIT_LO,
    ST_LAT_HI,
    ST_LAT_LO
  } shift_state_e;
endpackage

// File: rtl/gs_chan_regs.sv
module gs_chan_regs #(
  parameter int NUM_CH = 16,
  parameter int GS_W   = 12,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [ADDR_W-1:0]      wr_index,
  input  logic [GS_W-1:0]        wr_value,
  input  logic                   start,
  output logic [NUM_CH*GS_W-1:0] flat,
  output logic                   refresh_zero
);
  logic             wr_hit;
  logic [CNT_W-1:0] refresh_q;

  assign wr_hit = wr_valid && (32'(wr_index) < NUM_CH);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [GS_W-1:0] level_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        level_q <= '0;
      else if (wr_hit && (32'(wr_index) == i))
        level_q <= wr_value;
    end
    // channel 0 sits at the most significant end so it leaves first
    assign flat[(NUM_CH-1-i)*GS_W +: GS_W] = level_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      refresh_q <= '0;
    else if (start)
      refresh_q <= wr_hit ? CNT_W'(1) : '0;
    else if (wr_hit && (refresh_q != '1))
      refresh_q <= refresh_q + 1'b1;
  end

  assign refresh_zero = (refresh_q == '0);

  AST_REFRESH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !wr_hit) |=> (refresh_q == '0)); // R6
  AST_REFRESH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && wr_hit && (refresh_q != '1)) |=> (refresh_q == $past(refresh_q) + 1'b1)); // R6
endmodule

// File: rtl/gs_phase_timer.sv
module gs_phase_timer #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  if (CLK_DIV <= 1) begin : g_direct
    assign tick = run;
  end else begin : g_count
    localparam int DW = $clog2(CLK_DIV);
    logic [DW-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (!rst_n || !run)
        cnt_q <= '0;
      else if (cnt_q == DW'(CLK_DIV-1))
        cnt_q <= '0;
      else
        cnt_q <= cnt_q + 1'b1;
    end
    assign tick = run && (cnt_q == DW'(CLK_DIV-1));
  end
endmodule

// File: rtl/gs_shift_engine.sv
module gs_shift_engine
  import gs_shift_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int GS_W    = 12,
  parameter int CLK_DIV = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_req,
  input  logic                   refresh_zero,
  input  logic [NUM_CH*GS_W-1:0] flat,
  output logic                   start,
  output logic                   sdata,
  output logic                   sclk,
  output logic                   latch,
  output logic                   done
);
  localparam int TOTAL = NUM_CH * GS_W;
  localparam int BW    = $clog2(TOTAL + 1);

  shift_state_e     state_q, state_d;
  logic [TOTAL-1:0] sh_q;
  logic [BW-1:0]    left_q;
  logic             done_q;
  logic             tick;
  logic             run;

  assign run   = (state_q != ST_IDLE);
  assign start = (state_q == ST_IDLE) && frame_req && !refresh_zero;

  gs_phase_timer #(.CLK_DIV(CLK_DIV)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  always_comb begin
    state_d = state_q;
    if (state_q == ST_IDLE) begin
      if (start) state_d = ST_PRE_HI;
    end else if (tick) begin
      unique case (state_q)
        ST_PRE_HI: state_d = ST_PRE_LO;
        ST_PRE_LO: state_d = ST_SETUP;
        ST_SETUP:  state_d = ST_BIT_HI;
        ST_BIT_HI: state_d = ST_BIT_LO;
        ST_BIT_LO: state_d = (left_q == BW'(1)) ? ST_LAT_HI : ST_SETUP;
        ST_LAT_HI: state_d = ST_LAT_LO;
        ST_LAT_LO: state_d = ST_IDLE;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start) begin
          sh_q   <= flat;
          left_q <= BW'(TOTAL);
        end else if (frame_req) begin
          done_q <= 1'b1;
        end
      end else if (tick) begin
        if (state_q == ST_BIT_LO) begin
          sh_q   <= {sh_q[TOTAL-2:0], 1'b0};
          left_q <= left_q - 1'b1;
        end
        if (state_q == ST_LAT_LO) done_q <= 1'b1;
      end
    end
  end

  assign sdata = ((state_q == ST_SETUP) || (state_q == ST_BIT_HI) || (state_q == ST_BIT_LO))
                 ? sh_q[TOTAL-1] : 1'b0;
  assign sclk  = (state_q == ST_PRE_HI) || (state_q == ST_BIT_HI);
  assign latch = (state_q == ST_LAT_HI);
  assign done  = done_q;

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdata)); // R4
  AST_LATCH_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    latch |-> !sclk); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_EMPTY_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && frame_req && refresh_zero) |=> (done && !sclk && !latch)); // R7
endmodule

// File: rtl/gs_serial_shifter.sv
module gs_serial_shifter #(
  parameter int NUM_CH  = 16,
  parameter int GS_W    = 12,
  parameter int ADDR_W  = 5,
  parameter int CNT_W   = 8,
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_index,
  input  logic [GS_W-1:0]   wr_value,
  input  logic              frame_req,
  output logic              sdata,
  output logic              sclk,
  output logic              latch,
  output logic              done
);
  logic [NUM_CH*GS_W-1:0] flat;
  logic                   refresh_zero;
  logic                   start;

  assign wr_ready = 1'b1;

  gs_chan_regs #(
    .NUM_CH(NUM_CH), .GS_W(GS_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_index    (wr_index),
    .wr_value    (wr_value),
    .start       (start),
    .flat        (flat),
    .refresh_zero(refresh_zero)
  );

  gs_shift_engine #(
    .NUM_CH(NUM_CH), .GS_W(GS_W), .CLK_DIV(CLK_DIV)
  ) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_req   (frame_req),
    .refresh_zero(refresh_zero),
    .flat        (flat),
    .start       (start),
    .sdata       (sdata),
    .sclk        (sclk),
    .latch       (latch),
    .done        (done)
  );
endmodule

// File: tb/gs_serial_shifter_tb_top.sv
module gs_serial_shifter_tb_top;
  localparam int NCH = 16;
  localparam int DIV = 2;
  localparam int NB  = NCH * 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [4:0] wr_index = '0;
  logic [11:0] wr_value = '0;
  logic frame_req = 1'b0;
  logic sdata, sclk, latch, done;

  int n_chk = 0;
  int n_fail = 0;
  logic [11:0] model [NCH];
  logic [11:0] expv  [NCH];

  always #10 clk = ~clk;

  gs_serial_shifter #(.NUM_CH(NCH), .CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_index(wr_index), .wr_value(wr_value), .frame_req(frame_req),
    .sdata(sdata), .sclk(sclk), .latch(latch), .done(done)
  );

  // port monitor, sampled at the falling edge
  int edges = 0, hi_len = 0, bad_hi = 0, lat_len = 0, bad_lat = 0;
  int lat_cnt = 0, lat_ovl = 0, done_cnt = 0;
  logic prev_sclk = 1'b0, prev_lat = 1'b0;
  logic cap [256];
  always @(negedge clk) begin
    if (sclk && !prev_sclk) begin
      cap[edges % 256] = sdata;
      edges++;
    end
    if (sclk) hi_len++;
    if (!sclk && prev_sclk) begin
      if (hi_len != DIV) bad_hi++;
      hi_len = 0;
    end
    if (latch) begin
      lat_len++;
      if (sclk) lat_ovl++;
    end
    if (!latch && prev_lat) begin
      lat_cnt++;
      if (lat_len != DIV) bad_lat++;
      lat_len = 0;
    end
    if (done) done_cnt++;
    prev_sclk = sclk;
    prev_lat  = latch;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  task automatic host_write(input int idx, input int val, input bit with_req);
    @(negedge clk);
    wr_valid = 1'b1; wr_index = 5'(idx); wr_value = 12'(val); frame_req = with_req;
    @(negedge clk);
    wr_valid = 1'b0; frame_req = 1'b0;
    if (idx < NCH) model[idx] = 12'(val);
  endtask

  int b_edges, b_hi, b_lat, b_latc, b_ovl, b_done;

  task automatic begin_frame(input bit pulse);
    for (int i = 0; i < NCH; i++) expv[i] = model[i];
    b_edges = edges; b_hi = bad_hi; b_lat = bad_lat; b_latc = lat_cnt;
    b_ovl = lat_ovl; b_done = done_cnt;
    if (pulse) begin
      @(negedge clk); frame_req = 1'b1;
      @(negedge clk); frame_req = 1'b0;
    end
  endtask

  task automatic finish_frame(input string tag);
    int waited = 0;
    int mism = 0;
    int first_bad = -1;
    while (done_cnt == b_done && waited < 20000) begin
      @(negedge clk); waited++;
    end
    check(done_cnt == b_done + 1, {tag, " R10 done once"}, done_cnt - b_done, 1);
    check(edges - b_edges == NB + 1, {tag, " R2 edge count"}, edges - b_edges, NB + 1);
    check(cap[b_edges % 256] == 1'b0, {tag, " R3 dummy pulse data low"}, int'(cap[b_edges % 256]), 0);
    for (int k = 0; k < NB; k++) begin
      if (cap[(b_edges + 1 + k) % 256] != expv[k / 12][11 - (k % 12)]) begin
        mism++;
        if (first_bad < 0) first_bad = k;
      end
    end
    check(mism == 0, {tag, " R1 R2 bit stream, first bad bit index"}, first_bad, -1);
    check(lat_cnt - b_latc == 1 && lat_ovl == b_ovl, {tag, " R5 single latch, sclk low"},
          lat_cnt - b_latc, 1);
    check(bad_hi == b_hi && bad_lat == b_lat, {tag, " R9 phase widths"},
          (bad_hi - b_hi) + (bad_lat - b_lat), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!sclk && !sdata && !latch && !done, "R7 reset outputs idle",
          int'({sclk, sdata, latch, done}), 0);
    check(wr_ready == 1'b1, "R11 ready high", int'(wr_ready), 1);
  endtask

  task automatic t_skip_empty(input string tag);
    int e0 = edges;
    int l0 = lat_cnt;
    @(negedge clk); frame_req = 1'b1;
    @(negedge clk); frame_req = 1'b0;
    check(done == 1'b1, {tag, " R7 done next cycle"}, int'(done), 1);
    repeat (10) @(negedge clk);
    check(edges == e0 && lat_cnt == l0, {tag, " R7 no serial activity"}, edges - e0, 0);
  endtask

  task automatic t_pattern_a();
    for (int i = 0; i < NCH; i++) host_write(i, (i * 273 + 5) & 12'hFFF, 1'b0);
    begin_frame(1'b1);
    finish_frame("pattern_a");
  endtask

  task automatic t_pattern_b();
    for (int i = 0; i < NCH; i++) host_write(i, (i % 2 == 0) ? 12'h800 : 12'h001, 1'b0);
    host_write(NCH - 1, 12'hFFF, 1'b0);
    begin_frame(1'b1);
    finish_frame("pattern_b");
    t_skip_empty("after_b R6 cleared");
  endtask

  task automatic t_bad_index();
    host_write(NCH + 3, 12'hABC, 1'b0);
    t_skip_empty("R11 out of range not counted");
    host_write(2, 12'h5A5, 1'b0);
    begin_frame(1'b1);
    finish_frame("R11 levels unchanged");
  endtask

  task automatic t_snapshot();
    host_write(0, 12'h123, 1'b0);
    begin_frame(1'b1);
    repeat (60) @(negedge clk);
    host_write(0, 12'hF0F, 1'b0);
    host_write(7, 12'h0F0, 1'b0);
    finish_frame("R8 old snapshot");
    begin_frame(1'b1);
    finish_frame("R8 new values next frame");
  endtask

  task automatic t_write_at_start();
    host_write(4, 12'h444, 1'b0);
    for (int i = 0; i < NCH; i++) expv[i] = model[i];
    b_edges = edges; b_hi = bad_hi; b_lat = bad_lat; b_latc = lat_cnt;
    b_ovl = lat_ovl; b_done = done_cnt;
    host_write(5, 12'h555, 1'b1);
    finish_frame("R6 start frame");
    begin_frame(1'b1);
    finish_frame("R6 counted write sent");
  endtask

  task automatic t_busy_req();
    host_write(9, 12'h999, 1'b0);
    begin_frame(1'b1);
    repeat (100) @(negedge clk);
    frame_req = 1'b1;
    @(negedge clk); frame_req = 1'b0;
    finish_frame("R10 busy request");
    repeat (20) @(negedge clk);
    check(done_cnt == b_done + 1, "R10 busy request ignored", done_cnt - b_done, 1);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_skip_empty("empty");
    t_pattern_a();
    t_pattern_b();
    t_bad_index();
    t_snapshot();
    t_write_at_start();
    t_busy_req();
    summary();
  end
endmodule